// File: doc/BRIEF.md
# Memory-Mapped Register Stack Wrap Handler

This block keeps an eight-slot evaluation register stack in a simulated memory page rather than in physical registers. A wide signed register pointer (RP) selects the top of the stack. Each request is a read, write, push or pop, addressed relative to RP, and the block turns it into a slot index and a byte offset within the page. Because RP is a full-width signed value, it can drift past the ends of the stack without harm. Only a real access to a slot outside 0..7 causes a wrap fault. A fix-up step then shifts RP by eight toward the valid range and retries the access, which then completes.

The control path is a three-state machine. `ST_IDLE` accepts a request. On an out-of-range access it takes the transition *fault* into `ST_FIX`, where the fault pulse is shown and RP is adjusted. It then always takes the transition *adjust* into `ST_RETRY`, where the fix-up pulse is shown and the access is attempted again. From `ST_RETRY` the transition *complete* returns to `ST_IDLE` when the slot is now in range. The transition *refault* goes back to `ST_FIX` if the slot is still out of range. An in-range access in `ST_IDLE` completes at once and takes the transition *stay*. Requests are taken only in `ST_IDLE`; the requester holds off while `busy` is high.

The valid bit of the mode flag is an input. When it is clear, requests do not touch storage or RP and are only flagged as invalid. An RP load is taken in `ST_IDLE` on a cycle with no request, and it never faults.

Top module: `rstk_wrap_top`

## Requirements
- R1: An access that completes at slot n reports byte offset n*512 on `done_addr` with a one-cycle `done` pulse. A slot stores 16 bits, and a read or pop returns them on `rdata` with `rdata_valid`.
- R2: Operation codes on `req_op` are 00 read, 01 write, 10 push and 11 pop. Read and write use slot RP-k, where k is `req_sel`. Push first raises RP by one and then writes the slot at the new RP. Pop reads the slot at RP and then lowers RP by one.
- R3: An access whose slot index is 8 or more raises `fault` with `fault_dir`=1 (overflow), and RP is reduced by 8.
- R4: An access whose slot index is -1 or less raises `fault` with `fault_dir`=0 (underflow), and RP is raised by 8.
- R5: `fault` is a single-cycle pulse in the cycle after the faulting edge. `fixup` follows in the next cycle, and `busy` is high for both cycles. The access completes at the following edge, or faults again and repeats the two cycles if the index is still out of range.
- R6: Loading RP with any value, including -1 or values of 8 and above, raises no fault. Popping from RP=0 to -1 also raises no fault.
- R7: A request while `mode_valid` is low gives a one-cycle `invalid` pulse and no `done`. It leaves RP and all slot contents unchanged.
- R8: After reset, RP is -1, the block is idle and every slot reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_op | input | 2 | 00 read, 01 write, 10 push, 11 pop |
| req_sel | input | 3 | Offset k below RP for read and write |
| req_wdata | input | 16 | Data for write and push |
| mode_valid | input | 1 | Valid bit of the mode flag: stack slots in use |
| rp_load | input | 1 | Load RP from `rp_load_val` (idle, no request) |
| rp_load_val | input | 32 | Signed value to place in RP |
| busy | output | 1 | Fix-up in progress; new requests are not taken |
| fault | output | 1 | Wrap fault pulse |
| fault_dir | output | 1 | Fault direction: 1 overflow, 0 underflow |
| fixup | output | 1 | Pointer adjusted, retry under way |
| invalid | output | 1 | Request dropped because `mode_valid` was low |
| done | output | 1 | Access completed |
| done_addr | output | 12 | Byte offset of the completed access |
| rdata | output | 16 | Data from the last read or pop |
| rdata_valid | output | 1 | `rdata` updated this cycle |
| rp_out | output | 32 | Current signed register pointer |

## Verification
A wrong RP shows up at the next access in several ways. `rp_out` differs from the model in the cycle after the edge that changed it. The following access then lands on the wrong `done_addr`, or raises a fault the model did not predict. A state machine that stays in a wrong state shows as `busy`, `fault` or `fixup` out of step with the model within one or two cycles of the faulting edge. A bad slot write shows as wrong `rdata` at the first later read of that slot.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_PUSH  = 2'b10,
        OP_POP   = 2'b11
    } rstk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FIX   = 2'b01,
        ST_RETRY = 2'b10
    } rstk_state_e;
endpackage

// File: rtl/rstk_index.sv
module rstk_index
    import rstk_pkg::*;
#(
    parameter int RPW    = 32,
    parameter int NSLOT  = 8,
    parameter int STRIDE = 512,
    parameter int SELW   = 3,
    localparam int SLOTW  = $clog2(NSLOT),
    localparam int OFFW   = $clog2(STRIDE),
    localparam int ADDR_W = SLOTW + OFFW
) (
    input  logic signed [RPW-1:0] rp_i,
    input  rstk_op_e              op_i,
    input  logic [SELW-1:0]       sel_i,
    input  logic                  retry_i,
    output logic                  over_o,
    output logic                  under_o,
    output logic [SLOTW-1:0]      slot_o,
    output logic [ADDR_W-1:0]     addr_o
);
    localparam logic signed [RPW-1:0] ONE  = 1;
    localparam logic signed [RPW-1:0] LAST = NSLOT - 1;

    logic signed [RPW-1:0] idx;

    always_comb begin
        unique case (op_i)
            OP_PUSH: idx = retry_i ? rp_i : rp_i + ONE;
            OP_POP:  idx = rp_i;
            default: idx = rp_i - $signed({{(RPW-SELW){1'b0}}, sel_i});
        endcase
    end

    assign over_o  = idx > LAST;
    assign under_o = idx[RPW-1];
    assign slot_o  = idx[SLOTW-1:0];
    assign addr_o  = {slot_o, {OFFW{1'b0}}};
endmodule

// File: rtl/rstk_slots.sv
module rstk_slots #(
    parameter int NSLOT = 8,
    parameter int DW    = 16,
    localparam int SLOTW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SLOTW-1:0] wslot,
    input  logic [DW-1:0]    wdata,
    input  logic [SLOTW-1:0] rslot,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] slot_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (we && wslot == SLOTW'(g))
                slot_q[g] <= wdata;
        end
    end

    assign rdata = slot_q[rslot];
endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
#(
    parameter int RPW    = 32,
    parameter int NSLOT  = 8,
    parameter int STRIDE = 512,
    parameter int SELW   = 3,
    parameter int DW     = 16,
    localparam int SLOTW  = $clog2(NSLOT),
    localparam int ADDR_W = SLOTW + $clog2(STRIDE)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  rstk_op_e              req_op,
    input  logic [SELW-1:0]       req_sel,
    input  logic [DW-1:0]         req_wdata,
    input  logic                  mode_valid,
    input  logic                  rp_load,
    input  logic signed [RPW-1:0] rp_load_val,
    input  logic                  over_i,
    input  logic                  under_i,
    input  logic [SLOTW-1:0]      slot_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DW-1:0]         sdata_i,
    output logic signed [RPW-1:0] rp_o,
    output rstk_op_e              op_cur_o,
    output logic [SELW-1:0]       sel_cur_o,
    output logic                  retry_o,
    output logic                  we_o,
    output logic [SLOTW-1:0]      wslot_o,
    output logic [DW-1:0]         wdata_o,
    output logic                  busy,
    output logic                  fault,
    output logic                  fault_dir,
    output logic                  fixup,
    output logic                  invalid,
    output logic                  done,
    output logic [ADDR_W-1:0]     done_addr,
    output logic [DW-1:0]         rdata,
    output logic                  rdata_valid
);
    localparam logic signed [RPW-1:0] ONE  = 1;
    localparam logic signed [RPW-1:0] WRAP = NSLOT;

    rstk_state_e state_q, state_d;
    logic signed [RPW-1:0] rp_q;
    rstk_op_e        pend_op_q;
    logic [SELW-1:0] pend_sel_q;
    logic [DW-1:0]   pend_wd_q;
    logic            dir_q, inv_q, done_q, rv_q;
    logic [ADDR_W-1:0] daddr_q;
    logic [DW-1:0]   rdata_q;

    logic take, in_range, exec, is_rd, is_wr;

    assign take      = (state_q == ST_IDLE) && req_valid;
    assign in_range  = !(over_i || under_i);
    assign retry_o   = (state_q == ST_RETRY);
    assign op_cur_o  = retry_o ? pend_op_q : req_op;
    assign sel_cur_o = retry_o ? pend_sel_q : req_sel;
    assign wdata_o   = retry_o ? pend_wd_q : req_wdata;
    assign exec      = in_range && ((take && mode_valid) || retry_o);
    assign is_wr     = (op_cur_o == OP_WRITE) || (op_cur_o == OP_PUSH);
    assign is_rd     = (op_cur_o == OP_READ) || (op_cur_o == OP_POP);
    assign we_o      = exec && is_wr;
    assign wslot_o   = slot_i;
    assign rp_o      = rp_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take && mode_valid && !in_range) state_d = ST_FIX;
            ST_FIX:   state_d = ST_RETRY;
            ST_RETRY: state_d = in_range ? ST_IDLE : ST_FIX;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q       <= -ONE;
            pend_op_q  <= OP_READ;
            pend_sel_q <= '0;
            pend_wd_q  <= '0;
            dir_q      <= 1'b0;
            inv_q      <= 1'b0;
            done_q     <= 1'b0;
            rv_q       <= 1'b0;
            daddr_q    <= '0;
            rdata_q    <= '0;
        end else begin
            inv_q  <= take && !mode_valid;
            done_q <= exec;
            rv_q   <= exec && is_rd;
            if (exec) daddr_q <= addr_i;
            if (exec && is_rd) rdata_q <= sdata_i;
            if (state_d == ST_FIX && state_q != ST_FIX) dir_q <= over_i;
            if (take) begin
                pend_op_q  <= req_op;
                pend_sel_q <= req_sel;
                pend_wd_q  <= req_wdata;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (take && mode_valid) begin
                        if (req_op == OP_PUSH)
                            rp_q <= rp_q + ONE;
                        else if (req_op == OP_POP && in_range)
                            rp_q <= rp_q - ONE;
                    end else if (!req_valid && rp_load) begin
                        rp_q <= rp_load_val;
                    end
                end
                ST_FIX:   rp_q <= dir_q ? rp_q - WRAP : rp_q + WRAP;
                ST_RETRY: if (in_range && pend_op_q == OP_POP) rp_q <= rp_q - ONE;
                default:  ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        fault       = (state_q == ST_FIX);
        fixup       = (state_q == ST_RETRY);
        fault_dir   = dir_q;
        invalid     = inv_q;
        done        = done_q;
        done_addr   = daddr_q;
        rdata       = rdata_q;
        rdata_valid = rv_q;
    end

    // R5: fault lasts exactly one cycle
    a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);
    // R5: fault is always followed by fixup
    a_r5_fixup_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fixup);
    // R3: overflow fix lowers RP by eight
    a_r3_fix_down: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_dir) |=> (rp_q == $past(rp_q) - WRAP));
    // R4: underflow fix raises RP by eight
    a_r4_fix_up: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_dir) |=> (rp_q == $past(rp_q) + WRAP));
    // R7: dropped request leaves RP alone
    a_r7_invalid_keeps_rp: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (rp_q == $past(rp_q)));
    // R6: pointer load never faults
    a_r6_load_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid && rp_load) |=> !fault);
    // R1: a completion is never reported while busy
    a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/rstk_wrap_top.sv
module rstk_wrap_top
    import rstk_pkg::*;
#(
    parameter int RPW    = 32,
    parameter int NSLOT  = 8,
    parameter int STRIDE = 512,
    parameter int SELW   = 3,
    parameter int DW     = 16,
    localparam int SLOTW  = $clog2(NSLOT),
    localparam int ADDR_W = SLOTW + $clog2(STRIDE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [SELW-1:0]   req_sel,
    input  logic [DW-1:0]     req_wdata,
    input  logic              mode_valid,
    input  logic              rp_load,
    input  logic [RPW-1:0]    rp_load_val,
    output logic              busy,
    output logic              fault,
    output logic              fault_dir,
    output logic              fixup,
    output logic              invalid,
    output logic              done,
    output logic [ADDR_W-1:0] done_addr,
    output logic [DW-1:0]     rdata,
    output logic              rdata_valid,
    output logic [RPW-1:0]    rp_out
);
    logic signed [RPW-1:0] rp_w;
    rstk_op_e        op_cur;
    logic [SELW-1:0] sel_cur;
    logic            retry, over, under, we;
    logic [SLOTW-1:0] slot, wslot;
    logic [ADDR_W-1:0] addr;
    logic [DW-1:0]   wdata, sdata;

    rstk_index #(.RPW(RPW), .NSLOT(NSLOT), .STRIDE(STRIDE), .SELW(SELW)) u_index (
        .rp_i(rp_w), .op_i(op_cur), .sel_i(sel_cur), .retry_i(retry),
        .over_o(over), .under_o(under), .slot_o(slot), .addr_o(addr)
    );

    rstk_slots #(.NSLOT(NSLOT), .DW(DW)) u_slots (
        .clk(clk), .rst_n(rst_n), .we(we), .wslot(wslot), .wdata(wdata),
        .rslot(slot), .rdata(sdata)
    );

    rstk_ctrl #(.RPW(RPW), .NSLOT(NSLOT), .STRIDE(STRIDE), .SELW(SELW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(rstk_op_e'(req_op)),
        .req_sel(req_sel), .req_wdata(req_wdata), .mode_valid(mode_valid),
        .rp_load(rp_load), .rp_load_val($signed(rp_load_val)),
        .over_i(over), .under_i(under), .slot_i(slot), .addr_i(addr), .sdata_i(sdata),
        .rp_o(rp_w), .op_cur_o(op_cur), .sel_cur_o(sel_cur), .retry_o(retry),
        .we_o(we), .wslot_o(wslot), .wdata_o(wdata),
        .busy(busy), .fault(fault), .fault_dir(fault_dir), .fixup(fixup),
        .invalid(invalid), .done(done), .done_addr(done_addr), .rdata(rdata),
        .rdata_valid(rdata_valid)
    );

    assign rp_out = rp_w;
endmodule

// File: tb/sim_rstk_wrap_top.sv
`timescale 1ns/1ps
module sim_rstk_wrap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [2:0]  req_sel = 3'd0;
    logic [15:0] req_wdata = 16'h0;
    logic        mode_valid = 1'b1;
    logic        rp_load = 1'b0;
    logic [31:0] rp_load_val = 32'h0;
    logic        busy, fault, fault_dir, fixup, invalid, done, rdata_valid;
    logic [11:0] done_addr;
    logic [15:0] rdata;
    logic [31:0] rp_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int mrp;
    logic [15:0] mm [8];

    always #2.5 clk = ~clk;

    rstk_wrap_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .req_wdata(req_wdata), .mode_valid(mode_valid),
        .rp_load(rp_load), .rp_load_val(rp_load_val), .busy(busy), .fault(fault),
        .fault_dir(fault_dir), .fixup(fixup), .invalid(invalid), .done(done),
        .done_addr(done_addr), .rdata(rdata), .rdata_valid(rdata_valid), .rp_out(rp_out)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_index(input int op, input int k, input int rp);
        if (op == 2) return rp + 1;
        if (op == 3) return rp;
        return rp - k;
    endfunction

    task automatic load_rp(input int v);
        @(negedge clk);
        rp_load = 1'b1; rp_load_val = v;
        @(posedge clk);
        @(negedge clk);
        rp_load = 1'b0;
        mrp = v;
        chk($signed(rp_out) == mrp, "R6 rp after load", $signed(rp_out), mrp);
        chk(!fault && !busy, "R6 load gives no fault", fault, 0);
    endtask

    task automatic acc(input int op, input int k, input logic [15:0] wd, input bit mv,
                       input string tag);
        int idx, nf;
        bit dov;
        logic [15:0] exp_rd;
        nf = 0; dov = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_sel = 3'(k);
        req_wdata = wd; mode_valid = mv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; mode_valid = 1'b1;
        if (!mv) begin
            chk(invalid && !done && !busy, {tag, " R7 invalid pulse"}, invalid, 1);
            chk($signed(rp_out) == mrp, {tag, " R7 rp kept"}, $signed(rp_out), mrp);
            return;
        end
        idx = exp_index(op, k, mrp);
        if (op == 2) mrp = mrp + 1;
        while (idx > 7) begin mrp -= 8; idx -= 8; nf++; dov = 1; end
        while (idx < 0) begin mrp += 8; idx += 8; nf++; dov = 0; end
        exp_rd = mm[idx];
        if (op == 1 || op == 2) mm[idx] = wd;
        if (op == 3) mrp = mrp - 1;
        for (int f = 0; f < nf; f++) begin
            chk(fault && busy && !fixup, {tag, " R5 fault pulse"}, fault, 1);
            chk(fault_dir == dov, dov ? {tag, " R3 overflow dir"} : {tag, " R4 underflow dir"},
                fault_dir, dov);
            @(negedge clk);
            chk(fixup && busy && !fault, {tag, " R5 fixup cycle"}, fixup, 1);
            @(negedge clk);
        end
        chk(done && !busy && !fault, {tag, " R5 done after fix"}, done, 1);
        chk(done_addr == 12'(idx * 512), {tag, " R1 byte offset"}, done_addr, idx * 512);
        chk($signed(rp_out) == mrp, {tag, " R2 rp after access"}, $signed(rp_out), mrp);
        if (op == 0 || op == 3) begin
            chk(rdata_valid, {tag, " R1 rdata_valid"}, rdata_valid, 1);
            chk(rdata == exp_rd, {tag, " R2 read data"}, rdata, exp_rd);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) mm[i] = 16'h0;
        mrp = -1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk($signed(rp_out) == -1, "R8 reset rp", $signed(rp_out), -1);
        chk(!busy && !fault && !done && !invalid, "R8 reset idle", busy, 0);

        // R8: all slots zero
        load_rp(7);
        for (int k = 0; k < 8; k++) acc(0, k, 16'h0, 1, "R8 zero slot");

        // R2 push fill, then R3 overflow on ninth push
        load_rp(-1);
        for (int n = 0; n < 8; n++) acc(2, 0, 16'(16'hA100 + n), 1, "R2 push");
        acc(2, 0, 16'hBEEF, 1, "R3 push overflow");
        // R6 pop to empty, then R4 underflow pop
        acc(3, 0, 16'h0, 1, "R6 pop to empty");
        chk($signed(rp_out) == -1, "R6 empty rp", $signed(rp_out), -1);
        acc(3, 0, 16'h0, 1, "R4 pop underflow");
        acc(0, 7, 16'h0, 1, "R4 read below base");
        // R5 double fault from far overflow
        load_rp(20);
        acc(0, 0, 16'h0, 1, "R5 double overflow");
        load_rp(-9);
        acc(1, 2, 16'h5A5A, 1, "R5 double underflow");
        // R7 invalid write, then read back unchanged
        load_rp(3);
        acc(1, 0, 16'hDEAD, 0, "R7 dropped write");
        acc(0, 0, 16'h0, 1, "R7 slot unchanged");
        acc(2, 0, 16'h1234, 0, "R7 dropped push");
        acc(0, 0, 16'h0, 1, "R7 after dropped push");

        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 12;
            if (r == 0) load_rp(int'($urandom % 32) - 12);
            else acc(int'($urandom % 4), int'($urandom % 8), 16'($urandom),
                     ($urandom % 8) != 0, "R2 random");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule